// File: doc/BRIEF.md
# Masked Event Interrupt Controller with Read-to-Clear

This block collects thirteen single-cycle event pulses into a sticky raw status word. A software-programmable enable mask selects which of those latched events may raise the block's single level-sensitive interrupt line. Software sees the state through a small register port. It can read the raw word, the mask and the masked word.

Software acknowledges events by reading, not by writing. Each event that software may clear has its own clear address. A read there returns zero and drops that one latched bit. A further combined-clear address drops every bit at once, with two exceptions: the receive-threshold bit and the transmit-empty bit. Those two follow hardware conditions only. Dedicated strobes from the surrounding datapath clear them.

Register reads complete with one cycle of latency. Read data is registered and holds its value until the next read.

Top module: `irq_evt_ctrl`

## Requirements
- R1: A pulse on `evt_set[i]` latches raw bit i at the next clock edge. The bit stays set until cleared. Bit meanings: 0 rx-underflow, 1 rx-overflow, 2 rx-threshold (level), 3 tx-overflow, 4 tx-empty (level), 5 read-request, 6 tx-abort, 7 rx-done, 8 activity, 9 stop-seen, 10 start-seen, 11 general-call, 12 restart-seen.
- R2: `irq` is high exactly when (raw AND mask[12:0]) is non-zero. It follows a mask write from the cycle after that write. Mask bits 13 and 14 never affect `irq`.
- R3: Reading address 2 returns raw AND mask[12:0], zero-extended. Writes to address 2 are ignored. Reading address 0 returns the raw word.
- R4: Reading address 16+i, for i in 0..12 other than 2 and 4, returns zero and clears raw bit i only.
- R5: Reading address 3, the combined clear, returns zero and clears all raw bits except bits 2 and 4.
- R6: No software read ever clears raw bits 2 or 4. This includes reads at addresses 18 and 20. `lvl_clr[0]` clears bit 2 and `lvl_clr[1]` clears bit 4.
- R7: The mask lives at address 1. It is 15 bits wide and resets to 0x08FF. It is written from `wdata[14:0]`, and it reads back with bits 31..15 at zero.
- R8: While `rst_n` is low, `irq` is low. A synchronous reset clears the raw word and `rdata`.
- R9: If a set pulse and any clear (software read or level strobe) hit the same bit in the same cycle, the bit ends up set.
- R10: `rdata` updates at the clock edge that samples `rd_en` and then holds. Reads of unmapped addresses return zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set | input | 13 | Per-event set pulses |
| lvl_clr | input | 2 | Hardware clear strobes: [0] rx-threshold, [1] tx-empty |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions check several properties on every cycle. Set pulses always land, including when they collide with a clear. The two level bits survive any read. A combined clear empties every software-clearable bit. A single clear removes its bit. An all-zero mask write silences `irq`, and `irq` stays low during reset.

Some behaviour is shown only by the bench scenarios, where a behavioural model tracks every read value and the `irq` level. These scenarios cover the exact read data of each address, and the fact that a clear leaves the other bits untouched. They also cover the mask reset value and the width of its readback, the role of the inert mask bits 13 and 14, and ignored writes.

// File: rtl/irq_evt_pkg.sv
// Package: shared constants for the event interrupt controller.
// Assumes a word-addressed register port; addresses are word indices.
package irq_evt_pkg;
    localparam int NUM_EVT = 13;

    // Event bit positions (fixed: software decodes them)
    localparam int EVT_RX_UNDER  = 0;
    localparam int EVT_RX_OVER   = 1;
    localparam int EVT_RX_THRESH = 2;
    localparam int EVT_TX_OVER   = 3;
    localparam int EVT_TX_EMPTY  = 4;
    localparam int EVT_RD_REQ    = 5;
    localparam int EVT_TX_ABORT  = 6;
    localparam int EVT_RX_DONE   = 7;
    localparam int EVT_ACTIVITY  = 8;
    localparam int EVT_STOP      = 9;
    localparam int EVT_START     = 10;
    localparam int EVT_GEN_CALL  = 11;
    localparam int EVT_RESTART   = 12;

    // Bits owned by hardware: never cleared by software reads
    localparam logic [NUM_EVT-1:0] LEVEL_BITS =
        NUM_EVT'((1 << EVT_RX_THRESH) | (1 << EVT_TX_EMPTY));

    // Register word addresses
    localparam int ADR_RAW     = 0;
    localparam int ADR_MASK    = 1;
    localparam int ADR_MSTAT   = 2;
    localparam int ADR_CLR_ALL = 3;
    localparam int ADR_CLR_BASE = 16;

    // Read mux selection
    typedef enum logic [1:0] {
        SEL_ZERO  = 2'd0,
        SEL_RAW   = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_MSTAT = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/irq_raw_bank.sv
// Module: irq_raw_bank
// Holds the sticky raw event bits. Each bit is set by its pulse.
// Bits flagged in LEVEL_MASK accept only hardware clears; the other
// bits accept only software clears. A set pulse beats any clear.
// Assumes a synchronous active-low reset.
module irq_raw_bank #(
    parameter int N = 13,
    parameter logic [N-1:0] LEVEL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] sw_clr_i,
    input  logic [N-1:0] hw_clr_i,
    output logic [N-1:0] raw_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic clr_ok;
        // Pick the clear source this bit honours
        if (LEVEL_MASK[i]) begin : g_lvl
            assign clr_ok = hw_clr_i[i];
        end else begin : g_sw
            assign clr_ok = sw_clr_i[i];
        end

        // Per-bit sticky flag, set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                raw_o[i] <= 1'b1;
            end else if (clr_ok) begin
                raw_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// The interrupt enable mask. W bits are stored and reset to RST_VAL.
// Only the low bits, one per event, gate the interrupt; upper bits are storage only.
module irq_mask_reg #(
    parameter int W = 15,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    // Load on write, reset to the programmed default
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= RST_VAL;
        end else if (we_i) begin
            mask_o <= wdata_i;
        end
    end
endmodule

// File: rtl/irq_reg_decode.sv
// Module: irq_reg_decode
// Decodes the register port: the mask write enable, the software clear
// vector (one clear address per event plus a combined clear) and the
// read mux select. Purely combinational.
module irq_reg_decode
    import irq_evt_pkg::*;
#(
    parameter int N = 13,
    parameter int ADDR_W = 5
) (
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              mask_we_o,
    output logic [N-1:0]      sw_clr_o,
    output rd_sel_e           rd_sel_o
);
    logic clr_all;

    // Combined clear hit
    assign clr_all   = rd_en_i && (addr_i == ADDR_W'(ADR_CLR_ALL));
    // Mask is the only writable location
    assign mask_we_o = wr_en_i && (addr_i == ADDR_W'(ADR_MASK));

    for (genvar i = 0; i < N; i++) begin : g_clr
        // Per-event clear address hit or combined clear
        assign sw_clr_o[i] = clr_all ||
            (rd_en_i && (addr_i == ADDR_W'(ADR_CLR_BASE + i)));
    end

    // Read source selection; clear addresses and holes read zero
    always_comb begin
        case (addr_i)
            ADDR_W'(ADR_RAW):   rd_sel_o = SEL_RAW;
            ADDR_W'(ADR_MASK):  rd_sel_o = SEL_MASK;
            ADDR_W'(ADR_MSTAT): rd_sel_o = SEL_MSTAT;
            default:            rd_sel_o = SEL_ZERO;
        endcase
    end
endmodule

// File: rtl/irq_evt_ctrl.sv
// Module: irq_evt_ctrl (top)
// Event interrupt controller: sticky raw events, a 15-bit enable mask,
// a masked status view, read-to-clear acknowledgement and one level
// interrupt. Read data is registered (one cycle latency) and held.
// Assumes a synchronous active-low reset; irq is forced low while in reset.
module irq_evt_ctrl
    import irq_evt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int MASK_W = 15,
    parameter logic [MASK_W-1:0] MASK_RST = 15'h08FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [12:0]       evt_set,
    input  logic [1:0]        lvl_clr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int N = NUM_EVT;

    logic [N-1:0]      raw_q;
    logic [MASK_W-1:0] mask_q;
    logic [N-1:0]      sw_clr;
    logic [N-1:0]      hw_clr;
    logic              mask_we;
    rd_sel_e           rd_sel;
    logic [DATA_W-1:0] rd_val;

    // Route the two level strobes onto their event positions
    always_comb begin
        hw_clr                = '0;
        hw_clr[EVT_RX_THRESH] = lvl_clr[0];
        hw_clr[EVT_TX_EMPTY]  = lvl_clr[1];
    end

    irq_reg_decode #(.N(N), .ADDR_W(ADDR_W)) u_dec (
        .rd_en_i   (rd_en),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .mask_we_o (mask_we),
        .sw_clr_o  (sw_clr),
        .rd_sel_o  (rd_sel)
    );

    irq_raw_bank #(.N(N), .LEVEL_MASK(LEVEL_BITS)) u_raw (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_set),
        .sw_clr_i (sw_clr),
        .hw_clr_i (hw_clr),
        .raw_o    (raw_q)
    );

    irq_mask_reg #(.W(MASK_W), .RST_VAL(MASK_RST)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we),
        .wdata_i (wdata[MASK_W-1:0]),
        .mask_o  (mask_q)
    );

    // Read value mux from pre-clear state
    always_comb begin
        case (rd_sel)
            SEL_RAW:   rd_val = DATA_W'(raw_q);
            SEL_MASK:  rd_val = DATA_W'(mask_q);
            SEL_MSTAT: rd_val = DATA_W'(raw_q & mask_q[N-1:0]);
            default:   rd_val = '0;
        endcase
    end

    // Capture read data on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

    // Level interrupt, held low in reset
    assign irq = rst_n && (|(raw_q & mask_q[N-1:0]));
endmodule

// File: rtl/irq_evt_ctrl_chk.sv
// Module: irq_evt_ctrl_chk
// Property checker bound into irq_evt_ctrl. Observes ports plus the
// raw and mask registers.
module irq_evt_ctrl_chk
    import irq_evt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int MASK_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [12:0]       evt_set,
    input logic [1:0]        lvl_clr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic [12:0]       raw,
    input logic [MASK_W-1:0] mask
);
    // R1, R9: every pulsed bit is set one cycle later, whatever else happens
    a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != 13'd0) |=> ((raw & $past(evt_set)) == $past(evt_set)));

    // R6: rx-threshold survives unless its own strobe fires
    a_r6_thresh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[EVT_RX_THRESH] && !lvl_clr[0]) |=> raw[EVT_RX_THRESH]);

    // R6: tx-empty survives unless its own strobe fires
    a_r6_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[EVT_TX_EMPTY] && !lvl_clr[1]) |=> raw[EVT_TX_EMPTY]);

    // R5: combined clear empties every software-clearable bit
    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ADR_CLR_ALL) && evt_set == 13'd0)
        |=> ((raw & ~LEVEL_BITS) == 13'd0));

    // R4: a single clear read drops its bit
    a_r4_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ADR_CLR_BASE + EVT_TX_ABORT) && !evt_set[EVT_TX_ABORT])
        |=> !raw[EVT_TX_ABORT]);

    // R2: an all-zero mask write silences the interrupt
    a_r2_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADR_MASK) && wdata[12:0] == 13'd0) |=> !irq);

    // R8: interrupt low while reset is asserted
    a_r8_irq_reset: assert property (@(posedge clk) !rst_n |-> !irq);
endmodule

bind irq_evt_ctrl irq_evt_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .lvl_clr(lvl_clr),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .raw(raw_q), .mask(mask_q)
);

// File: tb/irq_evt_ctrl_tb.sv
`timescale 1ns/1ps
module irq_evt_ctrl_tb;
    localparam int A_RAW = 0, A_MASK = 1, A_MSTAT = 2, A_CLRALL = 3, A_CLR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] evt_set = '0;
    logic [1:0]  lvl_clr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    // Behavioural reference state
    logic [12:0] m_raw = '0;
    logic [14:0] m_mask = 15'h08FF;
    logic [31:0] m_rdata = '0;

    irq_evt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .lvl_clr(lvl_clr),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int a);
        if (a == A_RAW)   return {19'd0, m_raw};
        if (a == A_MASK)  return {17'd0, m_mask};
        if (a == A_MSTAT) return {19'd0, m_raw & m_mask[12:0]};
        return 32'd0;
    endfunction

    // Reference model update at each edge
    always @(posedge clk) begin
        logic [12:0] nraw;
        if (!rst_n) begin
            m_raw = '0; m_mask = 15'h08FF; m_rdata = '0;
        end else begin
            nraw = m_raw;
            if (rd_en) begin
                m_rdata = model_read(int'(addr));
                if (int'(addr) == A_CLRALL) nraw = nraw & 13'h0014;
                else if (int'(addr) >= A_CLR && int'(addr) < A_CLR + 13 &&
                         int'(addr) != A_CLR + 2 && int'(addr) != A_CLR + 4)
                    nraw[int'(addr) - A_CLR] = 1'b0;
            end
            if (lvl_clr[0]) nraw[2] = 1'b0;
            if (lvl_clr[1]) nraw[4] = 1'b0;
            nraw = nraw | evt_set;
            if (wr_en && int'(addr) == A_MASK) m_mask = wdata[14:0];
            m_raw = nraw;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            check(irq == (rst_n && |(m_raw & m_mask[12:0])), "R2 irq vs model",
                  {31'd0, irq}, {31'd0, rst_n && |(m_raw & m_mask[12:0])});
            check(rdata == m_rdata, "R10 rdata vs model", rdata, m_rdata);
        end
    end

    task automatic idle();
        @(negedge clk); #1;
        evt_set = '0; lvl_clr = '0; rd_en = 0; wr_en = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk); #1;
        evt_set = '0; lvl_clr = '0; wr_en = 0;
        rd_en = 1; addr = 5'(a);
        @(negedge clk); #1;
        rd_en = 0;
        v = rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); #1;
        evt_set = '0; lvl_clr = '0; rd_en = 0;
        wr_en = 1; addr = 5'(a); wdata = d;
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic pulse(input logic [12:0] s);
        @(negedge clk); #1;
        lvl_clr = '0; rd_en = 0; wr_en = 0;
        evt_set = s;
        @(negedge clk); #1;
        evt_set = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        #1;
        check(irq == 1'b0, "R8 irq low in reset", {31'd0, irq}, 32'd0);
        rst_n = 1;
        cmp_on = 1;
        idle();
        rd(A_MASK, v);  check(v == 32'h08FF, "R7 mask reset", v, 32'h08FF);
        rd(A_RAW, v);   check(v == 32'd0, "R8 raw reset", v, 32'd0);
        check(irq == 0, "R8 irq after reset", {31'd0, irq}, 32'd0);

        // R1/R2: set rx-underflow, enabled by default mask
        pulse(13'h0001);
        check(irq == 1, "R1 irq after set", {31'd0, irq}, 32'd1);
        rd(A_RAW, v);   check(v == 32'h1, "R1 raw bit0", v, 32'h1);

        // R2: mask write to zero drops irq the next cycle
        wr(A_MASK, 32'h0);
        check(irq == 0, "R2 irq off after mask 0", {31'd0, irq}, 32'd0);
        wr(A_MASK, 32'h6000);
        check(irq == 0, "R2 mask bits 13/14 inert", {31'd0, irq}, 32'd0);
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v);  check(v == 32'h7FFF, "R7 mask width", v, 32'h7FFF);
        check(irq == 1, "R2 irq on after mask all", {31'd0, irq}, 32'd1);

        // R3: masked view and ignored write
        pulse(13'h1A40);
        wr(A_MASK, 32'h0240);
        rd(A_MSTAT, v); check(v == 32'h0240, "R3 masked status", v, 32'h0240);
        wr(A_MSTAT, 32'h0);
        rd(A_RAW, v);   check(v == 32'h1A41, "R3 write to masked ignored", v, 32'h1A41);

        // R4: single clear of tx-abort
        rd(A_CLR + 6, v); check(v == 32'd0, "R4 clear read returns 0", v, 32'd0);
        rd(A_RAW, v);     check(v == 32'h1A01, "R4 only bit6 cleared", v, 32'h1A01);

        // R6: level bits survive software clears
        pulse(13'h1FFF);
        rd(A_CLR + 2, v); rd(A_CLR + 4, v);
        rd(A_RAW, v);     check(v == 32'h1FFF, "R6 level clear addrs inert", v, 32'h1FFF);
        // R5: combined clear
        rd(A_CLRALL, v);  check(v == 32'd0, "R5 clear-all returns 0", v, 32'd0);
        rd(A_RAW, v);     check(v == 32'h0014, "R5 level bits kept", v, 32'h0014);
        // R6: hardware strobes
        @(negedge clk); #1; lvl_clr = 2'b01;
        idle();
        rd(A_RAW, v);     check(v == 32'h0010, "R6 rx-threshold hw clear", v, 32'h0010);
        @(negedge clk); #1; lvl_clr = 2'b10;
        idle();
        rd(A_RAW, v);     check(v == 32'h0, "R6 tx-empty hw clear", v, 32'h0);

        // R9: set beats clear
        @(negedge clk); #1; rd_en = 1; addr = 5'(A_CLR + 7); evt_set = 13'h0080;
        idle();
        @(negedge clk); #1; lvl_clr = 2'b01; evt_set = 13'h0004;
        idle();
        rd(A_RAW, v);     check(v == 32'h0084, "R9 set wins", v, 32'h0084);

        // R10: unmapped read is zero and harmless; data holds
        rd(7, v);         check(v == 32'd0, "R10 unmapped read", v, 32'd0);
        rd(A_RAW, v);     idle(); idle();
        check(rdata == 32'h0084, "R10 rdata holds", rdata, 32'h0084);

        // Random traffic against the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #1;
            evt_set = ($urandom % 4 == 0) ? 13'($urandom) : 13'd0;
            lvl_clr = 2'($urandom);
            rd_en = 1'($urandom);
            wr_en = 1'($urandom % 3 == 0);
            addr = ($urandom % 2 == 0) ? 5'($urandom % 4) : 5'($urandom);
            wdata = $urandom;
        end
        idle();

        // R8: reset mid-run forces irq low
        pulse(13'h0001);
        wr(A_MASK, 32'h1);
        @(negedge clk); #1; rst_n = 0;
        @(negedge clk);
        check(irq == 0, "R8 irq low during reset", {31'd0, irq}, 32'd0);
        #1; rst_n = 1;
        rd(A_MASK, v);    check(v == 32'h08FF, "R7 mask after reset", v, 32'h08FF);

        cmp_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule